// File: doc/BRIEF.md
# Streaming Packet Transfer Scheduler

This block decides, one step at a time, which packet moves next over a parallel bus shared between a host-side endpoint buffer pair and a streaming data engine. Each time the bus reports idle, the block runs one pass in a fixed order. First it looks at the engine's transmit-underrun and receive-overrun lines. Any line that is set is latched into a sticky flag, and a one-cycle clear pulse goes back to the engine. Next it tries one outbound (transmit) packet, and then one inbound (receive) packet. Before each transfer starts, the fixed word count is set up, and the block then waits for the bus to go idle again. A finished inbound transfer is closed with a one-cycle commit pulse to the inbound endpoint.

The host reads the sticky flags through a small status port. The read returns the selected flag in the same cycle and clears it at the following clock edge. If the engine raises the same error in that cycle, the flag stays set and the event is not lost. A separate write strobe loads the transmit and receive enables.

The sequencer has these states: IDLE, SCAN, TX_CHK, TX_LOAD, TX_GO, TX_WAIT, RX_CHK, RX_LOAD, RX_GO, RX_WAIT and RX_COMMIT. The transitions are as follows:
- IDLE→SCAN when the bus is idle.
- SCAN→TX_CHK always.
- TX_CHK→TX_LOAD when transmit is ready, otherwise TX_CHK→RX_CHK.
- TX_LOAD→TX_GO→TX_WAIT.
- TX_WAIT→RX_CHK when the bus is idle again.
- RX_CHK→RX_LOAD when receive is ready, otherwise RX_CHK→IDLE.
- RX_LOAD→RX_GO→RX_WAIT.
- RX_WAIT→RX_COMMIT when the bus is idle again.
- RX_COMMIT→IDLE.

Top module: `pkt_xfer_sched`

## Requirements
- R1: `bus_start` is asserted only in a cycle where `bus_idle` is 1.
- R2: During the scan step of a pass, if `eng_tx_underrun` or `eng_rx_overrun` is 1, `eng_clr_flags` pulses high for exactly one cycle. At the next edge, the matching sticky flag is set (underrun is flag 0, overrun is flag 1).
- R3: A transmit start (`bus_start`=1 with `bus_rd`=0) happens only if, two cycles earlier, three conditions held together: the transmit enable was 1, `out_fifo_empty` was 0 and `eng_tx_room` was 1.
- R4: A receive start (`bus_start`=1 with `bus_rd`=1) happens only if, two cycles earlier, three conditions held together: the receive enable was 1, `in_fifo_full` was 0 and `eng_rx_avail` was 1.
- R5: While `bus_start` is high, `bus_cnt_hi` is 0x01 and `bus_cnt_lo` is 0x00, which is 256 words.
- R6: Each start lasts one cycle. The block does not continue until the bus is idle again. Within a pass, transmit comes before receive, so with both sides always ready the starts alternate TX, RX, TX.
- R7: `pkt_commit` pulses for one cycle only after a receive transfer. It comes in the cycle after the first idle cycle that follows that transfer's busy period, and `bus_rd` is 1 at that time.
- R8: `stat_data` shows the flag picked by `stat_sel` (0 selects underrun, 1 selects overrun) in the same cycle. When `stat_rd` is 1, that flag is 0 after the edge.
- R9: If a flag is set and read-cleared at the same edge, it ends up 1.
- R10: After reset, the following are all zero: both flags, both enables, the count outputs, `bus_start`, `pkt_commit` and `eng_clr_flags`. With the enables at their reset value, no transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Write strobe for the enables |
| ctl_tx_en | input | 1 | Transmit enable value to write |
| ctl_rx_en | input | 1 | Receive enable value to write |
| out_fifo_empty | input | 1 | Outbound endpoint FIFO is empty |
| in_fifo_full | input | 1 | Inbound endpoint FIFO is full |
| eng_tx_room | input | 1 | Engine can accept a whole packet |
| eng_rx_avail | input | 1 | Engine has a packet ready |
| eng_tx_underrun | input | 1 | Engine transmit underrun status |
| eng_rx_overrun | input | 1 | Engine receive overrun status |
| eng_clr_flags | output | 1 | Pulse that tells the engine to clear its status lines |
| bus_idle | input | 1 | Shared bus is idle |
| bus_start | output | 1 | One-cycle transfer start |
| bus_rd | output | 1 | Transfer direction: 1 means receive, 0 means transmit |
| bus_cnt_hi | output | 8 | Word count, high byte |
| bus_cnt_lo | output | 8 | Word count, low byte |
| pkt_commit | output | 1 | Packet-end commit for the inbound endpoint |
| stat_rd | input | 1 | Status read strobe (clears the selected flag) |
| stat_sel | input | 1 | Status select: 0 underrun, 1 overrun |
| stat_data | output | 1 | Selected flag value |

## Verification
A host status read that clears a flag can fall in the same cycle as a scan step that latches the same error. With both enables off, the pass has a fixed period of four cycles. The bench holds the overrun line high and times a clearing read of flag 1 to land four cycles after an observed clear pulse, which is exactly the next scan. It checks that the clear pulse and the read coincide, and that the flag still reads 1 afterwards. Random phases repeat this overlap for both flags, and a bench model decides which outcome is expected.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SCAN,
        ST_TX_CHK,
        ST_TX_LOAD,
        ST_TX_GO,
        ST_TX_WAIT,
        ST_RX_CHK,
        ST_RX_LOAD,
        ST_RX_GO,
        ST_RX_WAIT,
        ST_RX_COMMIT
    } sched_state_e;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } xfer_dir_e;

    localparam int unsigned ERR_UND = 0;
    localparam int unsigned ERR_OVR = 1;
    localparam int unsigned NUM_ERR = 2;

endpackage

// File: rtl/pxs_err_sticky.sv
module pxs_err_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q); // R9
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_q); // R8

endmodule

// File: rtl/pxs_len_reg.sv
module pxs_len_reg #(
    parameter int unsigned XFER_WORDS = 256,
    parameter int unsigned CNT_BYTES  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic                   load_rx_i,
    output logic [8*CNT_BYTES-1:0] cnt_o,
    output logic                   rx_o
);

    localparam int unsigned CNT_W = 8 * CNT_BYTES;

    logic [CNT_W-1:0] cnt_q;
    logic             rx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rx_q  <= 1'b0;
        end else if (load_i) begin
            cnt_q <= CNT_W'(XFER_WORDS);
            rx_q  <= load_rx_i;
        end
    end

    assign cnt_o = cnt_q;
    assign rx_o  = rx_q;

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == CNT_W'(XFER_WORDS))); // R5

endmodule

// File: rtl/pxs_sched_fsm.sv
module pxs_sched_fsm
    import pxs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_idle,
    input  logic tx_ready,
    input  logic rx_ready,
    output logic scan_o,
    output logic load_o,
    output logic load_rx_o,
    output logic start_o,
    output logic commit_o
);

    sched_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (bus_idle) state_d = ST_SCAN;
            ST_SCAN:      state_d = ST_TX_CHK;
            ST_TX_CHK:    state_d = tx_ready ? ST_TX_LOAD : ST_RX_CHK;
            ST_TX_LOAD:   state_d = ST_TX_GO;
            ST_TX_GO:     state_d = ST_TX_WAIT;
            ST_TX_WAIT:   if (bus_idle) state_d = ST_RX_CHK;
            ST_RX_CHK:    state_d = rx_ready ? ST_RX_LOAD : ST_IDLE;
            ST_RX_LOAD:   state_d = ST_RX_GO;
            ST_RX_GO:     state_d = ST_RX_WAIT;
            ST_RX_WAIT:   if (bus_idle) state_d = ST_RX_COMMIT;
            ST_RX_COMMIT: state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        scan_o    = (state_q == ST_SCAN);
        load_o    = (state_q == ST_TX_LOAD) || (state_q == ST_RX_LOAD);
        load_rx_o = (state_q == ST_RX_LOAD);
        start_o   = (state_q == ST_TX_GO) || (state_q == ST_RX_GO);
        commit_o  = (state_q == ST_RX_COMMIT);
    end

    AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o); // R6
    AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o); // R7

endmodule

// File: rtl/pkt_xfer_sched.sv
module pkt_xfer_sched
    import pxs_pkg::*;
#(
    parameter int unsigned XFER_WORDS = 256,
    parameter int unsigned CNT_BYTES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we,
    input  logic       ctl_tx_en,
    input  logic       ctl_rx_en,
    input  logic       out_fifo_empty,
    input  logic       in_fifo_full,
    input  logic       eng_tx_room,
    input  logic       eng_rx_avail,
    input  logic       eng_tx_underrun,
    input  logic       eng_rx_overrun,
    output logic       eng_clr_flags,
    input  logic       bus_idle,
    output logic       bus_start,
    output logic       bus_rd,
    output logic [7:0] bus_cnt_hi,
    output logic [7:0] bus_cnt_lo,
    output logic       pkt_commit,
    input  logic       stat_rd,
    input  logic       stat_sel,
    output logic       stat_data
);

    localparam int unsigned CNT_W = 8 * CNT_BYTES;

    logic tx_en_q, rx_en_q;
    logic tx_ready, rx_ready;
    logic scan, load, load_rx, start, commit, len_rx;
    logic [CNT_W-1:0]   cnt;
    logic [NUM_ERR-1:0] err_line, err_flag;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_q <= 1'b0;
            rx_en_q <= 1'b0;
        end else if (ctl_we) begin
            tx_en_q <= ctl_tx_en;
            rx_en_q <= ctl_rx_en;
        end
    end

    assign tx_ready = tx_en_q && !out_fifo_empty && eng_tx_room;
    assign rx_ready = rx_en_q && !in_fifo_full && eng_rx_avail;

    pxs_sched_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_idle  (bus_idle),
        .tx_ready  (tx_ready),
        .rx_ready  (rx_ready),
        .scan_o    (scan),
        .load_o    (load),
        .load_rx_o (load_rx),
        .start_o   (start),
        .commit_o  (commit)
    );

    pxs_len_reg #(
        .XFER_WORDS (XFER_WORDS),
        .CNT_BYTES  (CNT_BYTES)
    ) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .load_rx_i (load_rx),
        .cnt_o     (cnt),
        .rx_o      (len_rx)
    );

    assign err_line[ERR_UND] = eng_tx_underrun;
    assign err_line[ERR_OVR] = eng_rx_overrun;

    for (genvar g = 0; g < NUM_ERR; g++) begin : g_err
        pxs_err_sticky u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (scan && err_line[g]),
            .clr_i  (stat_rd && (stat_sel == 1'(g))),
            .flag_o (err_flag[g])
        );
    end

    assign eng_clr_flags = scan && (|err_line);
    assign bus_start     = start;
    assign bus_rd        = len_rx;
    assign bus_cnt_hi    = cnt[15:8];
    assign bus_cnt_lo    = cnt[7:0];
    assign pkt_commit    = commit;
    assign stat_data     = err_flag[stat_sel];

    AST_START_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |-> bus_idle); // R1
    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_clr_flags |=> !eng_clr_flags); // R2
    AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && !bus_rd) |-> $past(tx_en_q && !out_fifo_empty && eng_tx_room, 2)); // R3
    AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && bus_rd) |-> $past(rx_en_q && !in_fifo_full && eng_rx_avail, 2)); // R4
    AST_CNT_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |-> ({bus_cnt_hi, bus_cnt_lo} == 16'(XFER_WORDS))); // R5
    AST_COMMIT_RX: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_commit |-> (bus_rd && bus_idle)); // R7

endmodule

// File: tb/pkt_xfer_sched_test.sv
module pkt_xfer_sched_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_we = 0, ctl_tx_en = 0, ctl_rx_en = 0;
    logic out_fifo_empty = 1, in_fifo_full = 1, eng_tx_room = 0, eng_rx_avail = 0;
    logic eng_tx_underrun = 0, eng_rx_overrun = 0;
    logic eng_clr_flags, bus_idle, bus_start, bus_rd, pkt_commit;
    logic [7:0] bus_cnt_hi, bus_cnt_lo;
    logic stat_rd = 0, stat_sel = 0, stat_data;

    always #5 clk = ~clk;

    pkt_xfer_sched uut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_tx_en(ctl_tx_en),
        .ctl_rx_en(ctl_rx_en), .out_fifo_empty(out_fifo_empty),
        .in_fifo_full(in_fifo_full), .eng_tx_room(eng_tx_room),
        .eng_rx_avail(eng_rx_avail), .eng_tx_underrun(eng_tx_underrun),
        .eng_rx_overrun(eng_rx_overrun), .eng_clr_flags(eng_clr_flags),
        .bus_idle(bus_idle), .bus_start(bus_start), .bus_rd(bus_rd),
        .bus_cnt_hi(bus_cnt_hi), .bus_cnt_lo(bus_cnt_lo),
        .pkt_commit(pkt_commit), .stat_rd(stat_rd), .stat_sel(stat_sel),
        .stat_data(stat_data)
    );

    // bus model: goes busy at the edge that samples a start
    logic [7:0] busy_left;
    int unsigned bus_xfers;
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_idle  <= 1'b1;
            busy_left <= 8'd0;
            bus_xfers <= 0;
        end else if (bus_start) begin
            bus_idle  <= 1'b0;
            busy_left <= 8'(1 + (bus_xfers % 5));
            bus_xfers <= bus_xfers + 1;
        end else if (!bus_idle) begin
            if (busy_left == 8'd0) bus_idle <= 1'b1;
            else busy_left <= busy_left - 8'd1;
        end
    end

    int n_chk = 0, n_bad = 0;
    bit nx_we = 0, nx_ten = 0, nx_ren = 0, nx_empty = 1, nx_full = 1;
    bit nx_room = 0, nx_avail = 0, nx_rd = 0, nx_sel = 0;
    bit und_line = 0, ovr_line = 0, eng_hold = 0;
    bit en_tx_m = 0, en_rx_m = 0, exp_und = 0, exp_ovr = 0;
    bit tx_h1 = 0, tx_h2 = 0, rx_h1 = 0, rx_h2 = 0;
    bit rx_active = 0, busy_seen = 0, commit_due = 0;
    int n_start = 0, n_tx = 0, n_rx = 0;
    bit dir_log [0:15];
    bit clr_seen;

    function automatic bit tx_gate(bit en, bit empty, bit room);
        return en && !empty && room;
    endfunction

    function automatic bit rx_gate(bit en, bit full, bit avail);
        return en && !full && avail;
    endfunction

    function automatic bit flag_next(bit cur, bit set, bit clr);
        return set ? 1'b1 : (clr ? 1'b0 : cur);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic cycle();
        bit cur_tx, cur_rx;
        @(negedge clk);
        ctl_we = nx_we; ctl_tx_en = nx_ten; ctl_rx_en = nx_ren;
        out_fifo_empty = nx_empty; in_fifo_full = nx_full;
        eng_tx_room = nx_room; eng_rx_avail = nx_avail;
        eng_tx_underrun = und_line; eng_rx_overrun = ovr_line;
        stat_rd = nx_rd; stat_sel = nx_sel;
        nx_we = 0; nx_rd = 0;
        #1;
        clr_seen = eng_clr_flags;
        // R8: same-cycle status value
        chk(stat_data == (stat_sel ? exp_ovr : exp_und), "R8", "stat_data",
            stat_data, stat_sel ? exp_ovr : exp_und);
        // R7: commit exactly when due
        chk(pkt_commit == commit_due, "R7", "pkt_commit", pkt_commit, commit_due);
        if (pkt_commit) chk(bus_rd == 1'b1, "R7", "bus_rd at commit", bus_rd, 1);
        // R2: clear pulse only with an error line and an idle bus
        if (eng_clr_flags)
            chk((und_line || ovr_line) && bus_idle, "R2", "clr_flags context",
                int'(und_line || ovr_line), 1);
        if (bus_start) begin
            chk(bus_idle == 1'b1, "R1", "bus_idle at start", bus_idle, 1);
            chk({bus_cnt_hi, bus_cnt_lo} == 16'h0100, "R5", "word count",
                {bus_cnt_hi, bus_cnt_lo}, 16'h0100);
            if (!bus_rd) begin
                chk(tx_h2, "R3", "tx gate two cycles before start", tx_h2, 1);
                n_tx++;
            end else begin
                chk(rx_h2, "R4", "rx gate two cycles before start", rx_h2, 1);
                n_rx++;
            end
            if (n_start < 16) dir_log[n_start] = bus_rd;
            n_start++;
        end
        // model updates for the coming edge
        commit_due = 0;
        if (bus_start && bus_rd) begin
            rx_active = 1; busy_seen = 0;
        end else if (rx_active && !bus_idle) begin
            busy_seen = 1;
        end else if (rx_active && busy_seen && bus_idle) begin
            commit_due = 1; rx_active = 0;
        end
        exp_und = flag_next(exp_und, eng_clr_flags && und_line, stat_rd && !stat_sel);
        exp_ovr = flag_next(exp_ovr, eng_clr_flags && ovr_line, stat_rd && stat_sel);
        cur_tx = tx_gate(en_tx_m, out_fifo_empty, eng_tx_room);
        cur_rx = rx_gate(en_rx_m, in_fifo_full, eng_rx_avail);
        tx_h2 = tx_h1; tx_h1 = cur_tx;
        rx_h2 = rx_h1; rx_h1 = cur_rx;
        if (ctl_we) begin
            en_tx_m = ctl_tx_en; en_rx_m = ctl_rx_en;
        end
        if (eng_clr_flags && !eng_hold) begin
            und_line = 0; ovr_line = 0;
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic set_en(bit t, bit r);
        nx_we = 1; nx_ten = t; nx_ren = r;
        cycle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        int s0;
        void'($urandom(32'd4242));
        // R10: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(bus_start == 0 && pkt_commit == 0 && eng_clr_flags == 0, "R10",
            "pulses in reset", int'(bus_start | pkt_commit | eng_clr_flags), 0);
        chk({bus_cnt_hi, bus_cnt_lo} == 16'h0, "R10", "count in reset",
            {bus_cnt_hi, bus_cnt_lo}, 0);
        chk(stat_data == 0, "R10", "underrun flag in reset", stat_data, 0);
        stat_sel = 1; #1;
        chk(stat_data == 0, "R10", "overrun flag in reset", stat_data, 0);
        @(negedge clk); rst_n = 1'b1;

        // R10: enables reset to zero, so no start even with everything ready
        nx_empty = 0; nx_room = 1; nx_full = 0; nx_avail = 1;
        run(30);
        chk(n_start == 0, "R10", "starts with reset enables", n_start, 0);

        // R6: order TX, RX, TX with both sides ready
        n_start = 0;
        set_en(1, 1);
        for (int i = 0; i < 200 && n_start < 3; i++) cycle();
        chk(n_start >= 3, "R6", "starts seen", n_start, 3);
        chk(dir_log[0] == 0, "R6", "first dir", dir_log[0], 0);
        chk(dir_log[1] == 1, "R6", "second dir", dir_log[1], 1);
        chk(dir_log[2] == 0, "R6", "third dir", dir_log[2], 0);

        // R3: tx enabled but outbound FIFO empty, rx off
        set_en(1, 0);
        run(20);
        nx_empty = 1; run(4);
        s0 = n_start; run(30);
        chk(n_start == s0, "R3", "starts with empty FIFO", n_start - s0, 0);
        // R4: rx enabled but inbound FIFO full
        set_en(0, 1);
        nx_full = 1; run(4);
        s0 = n_start; run(30);
        chk(n_start == s0, "R4", "starts with full FIFO", n_start - s0, 0);
        set_en(0, 0);
        nx_full = 0; nx_empty = 0; run(10);

        // R2/R8: underrun latched, then read-cleared
        und_line = 1;
        for (int i = 0; i < 10 && !clr_seen; i++) cycle();
        chk(clr_seen, "R2", "clear pulse seen", clr_seen, 1);
        cycle();
        chk(und_line == 0, "R2", "engine line cleared", und_line, 0);
        nx_sel = 0; nx_rd = 1; cycle();
        chk(stat_data == 1, "R8", "underrun read value", stat_data, 1);
        cycle();
        chk(stat_data == 0, "R8", "underrun after read", stat_data, 0);

        // R9: clearing read in the same cycle as a scan that latches overrun
        eng_hold = 1; ovr_line = 1;
        clr_seen = 0;
        for (int i = 0; i < 10 && !clr_seen; i++) cycle();
        run(3);
        nx_sel = 1; nx_rd = 1; cycle();
        chk(clr_seen, "R9", "scan coincides with read", clr_seen, 1);
        eng_hold = 0; ovr_line = 0;
        cycle();
        chk(stat_data == 1, "R9", "overrun kept after same-edge read", stat_data, 1);
        nx_sel = 1; nx_rd = 1; cycle();
        cycle();
        chk(stat_data == 0, "R8", "overrun after clean read", stat_data, 0);

        // random phase
        n_tx = 0; n_rx = 0;
        for (int i = 0; i < 5000; i++) begin
            nx_empty = ($urandom % 4) == 0;
            nx_full  = ($urandom % 5) == 0;
            nx_room  = ($urandom % 3) != 0;
            nx_avail = ($urandom % 2) != 0;
            if (($urandom % 60) == 0) begin
                nx_we = 1; nx_ten = ($urandom % 4) != 0; nx_ren = ($urandom % 4) != 0;
            end
            if (($urandom % 40) == 0) und_line = 1;
            if (($urandom % 45) == 0) ovr_line = 1;
            if (($urandom % 8) == 0) begin
                nx_rd = 1; nx_sel = $urandom % 2;
            end
            cycle();
        end
        chk(n_tx > 0 && n_rx > 0, "R6", "both directions in random phase", n_tx * n_rx, 1);
        summary();
    end

endmodule